// File: doc/BRIEF.md
# Eight-Bit Accumulator Computer

A small stored-program processor for teaching. It has an 8-bit data path and a 16-word by 8-bit memory that holds both the program and its data. Internally it has a program counter, a memory address register, an instruction register and an accumulator. It also has a second operand register and a combinational two's-complement adder-subtractor. An output register drives eight LEDs. A sequencer steps through six timing states per instruction and emits a 12-bit control word on every clock. The data path moves one value per cycle over a shared internal bus.

Use has two phases.

- **Program phase** (`runMode` low): each word is written into memory from the address and data switches by holding `writeStrobe` high across a rising edge.
- **Run phase** (`runMode` high): execution starts at address 0 and continues until a halt instruction freezes the machine. The machine stays frozen until reset.

An instruction word carries the operation in its upper four bits and a memory address in its lower four bits.

Top module: `tcpu_top`

## Requirements
- R1: While `rstN` is low, and immediately after it, `leds` reads 0 and `halted` reads 0. Asserting reset in the middle of a run returns both to 0.
- R2: With `runMode` low, a rising edge with `writeStrobe` high stores `dataSw` into word `addrSw`. With `runMode` high, the strobe is ignored and memory is unchanged.
- R3: An instruction word has the opcode in bits 7:4 and an operand address in bits 3:0. Opcode 0x0 (load) copies memory[address] into the accumulator.
- R4: Opcode 0x1 (add) sets accumulator = accumulator + memory[address], modulo 256.
- R5: Opcode 0x2 (subtract) sets accumulator = accumulator - memory[address], modulo 256.
- R6: Opcode 0xE (output) copies the accumulator to `leds`. The copy happens on the 4th rising edge of that instruction. `leds` changes on no other edge.
- R7: Opcode 0xF (halt) raises `halted` on the 4th rising edge of that instruction. `halted` stays high until reset, and `leds` then holds its value.
- R8: Any other opcode (0x3 to 0xD) is a no-operation and leaves the accumulator unchanged.
- R9: Every instruction occupies six clock cycles. The first rising edge with `runMode` high begins the instruction at address 0, so instruction k begins on run edge 6k+1.
- R10: The program counter wraps from address 15 to address 0, and execution continues there.
- R11: At most one source drives the internal bus in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| runMode | input | 1 | 1 = execute program, 0 = load memory from switches |
| addrSw | input | 4 | Address switches used in the program phase |
| dataSw | input | 8 | Data switches used in the program phase |
| writeStrobe | input | 1 | Memory write enable in the program phase |
| leds | output | 8 | Output register contents |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
The bench builds the block with its default widths: an 8-bit word and a 4-bit address. With these widths the whole 16-word memory can be written, and a program can run off the end of memory and wrap to address 0 within about a hundred cycles. Small operands are enough to cross the 8-bit overflow and underflow boundaries in both directions. The six-cycle instruction slot is short enough for the bench to predict exactly which edge changes `leds` and `halted` in every program.

// File: rtl/tcpu_pkg.sv
`timescale 1ns/1ps
package tcpu_pkg;
  localparam int DATA_W   = 8;
  localparam int ADDR_W   = 4;
  localparam int RING_LEN = 6;

  // timing-state positions in the ring
  localparam int ST_T1 = 0;
  localparam int ST_T2 = 1;
  localparam int ST_T3 = 2;
  localparam int ST_T4 = 3;
  localparam int ST_T5 = 4;
  localparam int ST_T6 = 5;

  localparam logic [3:0] OP_LDA = 4'h0;
  localparam logic [3:0] OP_ADD = 4'h1;
  localparam logic [3:0] OP_SUB = 4'h2;
  localparam logic [3:0] OP_OUT = 4'hE;
  localparam logic [3:0] OP_HLT = 4'hF;

  // 12-bit flat control word
  typedef struct packed {
    logic pcInc;
    logic pcOut;
    logic marLoad;
    logic memRead;
    logic irLoad;
    logic irOut;
    logic accLoad;
    logic accOut;
    logic aluSub;
    logic aluOut;
    logic bLoad;
    logic outLoad;
  } ctrl_t;
endpackage

// File: rtl/tcpu_addsub.sv
`timescale 1ns/1ps
module tcpu_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic         doSub,
  output logic [W-1:0] result
);
  logic [W-1:0] carry;
  assign carry[0] = doSub;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic bInv;
    assign bInv      = opB[i] ^ doSub;
    assign result[i] = opA[i] ^ bInv ^ carry[i];
    if (i < W - 1) begin : g_carry
      assign carry[i+1] = (opA[i] & bInv) | (carry[i] & (opA[i] ^ bInv));
    end
  end
endmodule

// File: rtl/tcpu_datapath.sv
`timescale 1ns/1ps
module tcpu_datapath
  import tcpu_pkg::*;
#(
  parameter int DATA_W = tcpu_pkg::DATA_W,
  parameter int ADDR_W = tcpu_pkg::ADDR_W
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     runMode,
  input  ctrl_t                    ctrl,
  input  logic [ADDR_W-1:0]        addrSw,
  input  logic [DATA_W-1:0]        dataSw,
  input  logic                     writeStrobe,
  output logic [DATA_W-ADDR_W-1:0] opcode,
  output logic [DATA_W-1:0]        outQ
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAD_W = DATA_W - ADDR_W;

  logic [ADDR_W-1:0] pcQ;
  logic [ADDR_W-1:0] marQ;
  logic [DATA_W-1:0] irQ;
  logic [DATA_W-1:0] accQ;
  logic [DATA_W-1:0] bQ;
  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] memAddr;
  logic [DATA_W-1:0] memWord;
  logic [DATA_W-1:0] aluRes;
  logic [DATA_W-1:0] busVal;

  // dual address source: sequencer path in run, switches in program
  assign memAddr = runMode ? marQ : addrSw;
  assign memWord = mem[memAddr];

  tcpu_addsub #(.W(DATA_W)) u_alu (
    .opA   (accQ),
    .opB   (bQ),
    .doSub (ctrl.aluSub),
    .result(aluRes)
  );

  // shared bus as OR of gated sources
  always_comb begin
    busVal = '0;
    if (ctrl.pcOut)   busVal = busVal | {{PAD_W{1'b0}}, pcQ};
    if (ctrl.memRead) busVal = busVal | memWord;
    if (ctrl.irOut)   busVal = busVal | {{PAD_W{1'b0}}, irQ[ADDR_W-1:0]};
    if (ctrl.accOut)  busVal = busVal | accQ;
    if (ctrl.aluOut)  busVal = busVal | aluRes;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcQ  <= '0;
      marQ <= '0;
      irQ  <= '0;
      accQ <= '0;
      bQ   <= '0;
      outQ <= '0;
    end else begin
      if (!runMode)         pcQ <= '0;
      else if (ctrl.pcInc)  pcQ <= pcQ + 1'b1;
      if (ctrl.marLoad)     marQ <= busVal[ADDR_W-1:0];
      if (ctrl.irLoad)      irQ  <= busVal;
      if (ctrl.accLoad)     accQ <= busVal;
      if (ctrl.bLoad)       bQ   <= busVal;
      if (ctrl.outLoad)     outQ <= busVal;
    end
  end

  always_ff @(posedge clk) begin
    if (writeStrobe && !runMode) mem[addrSw] <= dataSw;
  end

  assign opcode = irQ[DATA_W-1:ADDR_W];
endmodule

// File: rtl/tcpu_control.sv
`timescale 1ns/1ps
module tcpu_control
  import tcpu_pkg::*;
#(
  parameter int RING_LEN = tcpu_pkg::RING_LEN,
  parameter int OPC_W    = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                runMode,
  input  logic [OPC_W-1:0]    opcode,
  output ctrl_t               ctrl,
  output logic [RING_LEN-1:0] ring,
  output logic                halted
);
  logic haltNow;

  always_comb begin
    ctrl    = '0;
    haltNow = 1'b0;
    if (runMode && !halted) begin
      if (ring[ST_T1]) begin
        ctrl.pcOut   = 1'b1;
        ctrl.marLoad = 1'b1;
      end
      if (ring[ST_T2]) ctrl.pcInc = 1'b1;
      if (ring[ST_T3]) begin
        ctrl.memRead = 1'b1;
        ctrl.irLoad  = 1'b1;
      end
      if (ring[ST_T4]) begin
        case (opcode)
          OP_LDA, OP_ADD, OP_SUB: begin
            ctrl.irOut   = 1'b1;
            ctrl.marLoad = 1'b1;
          end
          OP_OUT: begin
            ctrl.accOut  = 1'b1;
            ctrl.outLoad = 1'b1;
          end
          OP_HLT:  haltNow = 1'b1;
          default: ;
        endcase
      end
      if (ring[ST_T5]) begin
        case (opcode)
          OP_LDA: begin
            ctrl.memRead = 1'b1;
            ctrl.accLoad = 1'b1;
          end
          OP_ADD, OP_SUB: begin
            ctrl.memRead = 1'b1;
            ctrl.bLoad   = 1'b1;
          end
          default: ;
        endcase
      end
      if (ring[ST_T6]) begin
        case (opcode)
          OP_ADD: begin
            ctrl.aluOut  = 1'b1;
            ctrl.accLoad = 1'b1;
          end
          OP_SUB: begin
            ctrl.aluOut  = 1'b1;
            ctrl.aluSub  = 1'b1;
            ctrl.accLoad = 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ring   <= RING_LEN'(1);
      halted <= 1'b0;
    end else begin
      if (!runMode)
        ring <= RING_LEN'(1);
      else if (!halted && !haltNow)
        ring <= {ring[RING_LEN-2:0], ring[RING_LEN-1]};
      halted <= halted | haltNow;
    end
  end
endmodule

// File: rtl/tcpu_top.sv
`timescale 1ns/1ps
module tcpu_top
  import tcpu_pkg::*;
#(
  parameter int DATA_W = tcpu_pkg::DATA_W,
  parameter int ADDR_W = tcpu_pkg::ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              runMode,
  input  logic [ADDR_W-1:0] addrSw,
  input  logic [DATA_W-1:0] dataSw,
  input  logic              writeStrobe,
  output logic [DATA_W-1:0] leds,
  output logic              halted
);
  localparam int OPC_W    = DATA_W - ADDR_W;
  localparam int RING_LEN = tcpu_pkg::RING_LEN;

  ctrl_t               ctrlWord;
  logic [OPC_W-1:0]    opcode;
  logic [RING_LEN-1:0] ringState;

  tcpu_control #(.RING_LEN(RING_LEN), .OPC_W(OPC_W)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .runMode(runMode),
    .opcode (opcode),
    .ctrl   (ctrlWord),
    .ring   (ringState),
    .halted (halted)
  );

  tcpu_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .runMode    (runMode),
    .ctrl       (ctrlWord),
    .addrSw     (addrSw),
    .dataSw     (dataSw),
    .writeStrobe(writeStrobe),
    .opcode     (opcode),
    .outQ       (leds)
  );
endmodule

// File: rtl/tcpu_checker.sv
`timescale 1ns/1ps
module tcpu_checker
  import tcpu_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int RING_LEN = 6
) (
  input logic                clk,
  input logic                rstN,
  input logic                runMode,
  input ctrl_t               ctrl,
  input logic [RING_LEN-1:0] ring,
  input logic [DATA_W-1:0]   leds,
  input logic                halted
);
  // R11
  bus_drivers_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctrl.pcOut, ctrl.memRead, ctrl.irOut, ctrl.accOut, ctrl.aluOut}));

  // R9
  ring_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(ring) == 1);

  // R7
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> halted);

  // R7
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    (halted && runMode) |=> $stable(ring));

  // R6
  leds_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.outLoad |=> $stable(leds));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !runMode |-> (ctrl == '0));
endmodule

bind tcpu_top tcpu_checker #(.DATA_W(DATA_W), .RING_LEN(RING_LEN)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .runMode(runMode),
  .ctrl   (ctrlWord),
  .ring   (ringState),
  .leds   (leds),
  .halted (halted)
);

// File: tb/tcpu_top_tb.sv
`timescale 1ns/1ps
module tcpu_top_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       runMode = 1'b0;
  logic [3:0] addrSw = '0;
  logic [7:0] dataSw = '0;
  logic       writeStrobe = 1'b0;
  logic [7:0] leds;
  logic       halted;

  int checks = 0;
  int errors = 0;
  logic [7:0] prog [16];

  // vector: {sub, a, b, expected}
  localparam logic [24:0] VEC [8] = '{
    {1'b0, 8'd3,   8'd4,   8'd7},
    {1'b0, 8'd200, 8'd100, 8'd44},
    {1'b0, 8'd127, 8'd1,   8'd128},
    {1'b0, 8'd255, 8'd1,   8'd0},
    {1'b1, 8'd10,  8'd3,   8'd7},
    {1'b1, 8'd5,   8'd10,  8'd251},
    {1'b1, 8'd0,   8'd1,   8'd255},
    {1'b1, 8'd128, 8'd128, 8'd0}
  };

  tcpu_top u_dut (
    .clk(clk), .rstN(rstN), .runMode(runMode), .addrSw(addrSw),
    .dataSw(dataSw), .writeStrobe(writeStrobe), .leds(leds), .halted(halted)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; runMode = 1'b0; writeStrobe = 1'b0;
    edges(2);
    rstN = 1'b1;
  endtask

  task automatic clearProg();
    for (int i = 0; i < 16; i++) prog[i] = 8'h00;
  endtask

  task automatic loadProg();
    for (int i = 0; i < 16; i++) begin
      addrSw = 4'(i); dataSw = prog[i]; writeStrobe = 1'b1;
      @(negedge clk);
    end
    writeStrobe = 1'b0;
  endtask

  initial begin
    // vector table: load / add-or-sub / out / halt
    for (int i = 0; i < 8; i++) begin
      doReset();
      clearProg();
      prog[0] = 8'h0E;
      prog[1] = VEC[i][24] ? 8'h2F : 8'h1F;
      prog[2] = 8'hE0;
      prog[3] = 8'hF0;
      prog[14] = VEC[i][23:16];
      prog[15] = VEC[i][15:8];
      loadProg();
      runMode = 1'b1;
      edges(15);
      chk("R6 leds before OUT edge", leds, 8'd0);
      edges(1);
      chk(VEC[i][24] ? "R5 sub result" : "R4 add result", leds, VEC[i][7:0]);
      edges(5);
      chk("R7 halted before 4th edge of HLT", {7'd0, halted}, 8'd0);
      edges(1);
      chk("R7 halted on 4th edge of HLT", {7'd0, halted}, 8'd1);
    end

    // R1 reset state
    doReset();
    chk("R1 leds after reset", leds, 8'd0);
    chk("R1 halted after reset", {7'd0, halted}, 8'd0);

    // R3 load, R8 no-ops, R9 slot timing
    clearProg();
    prog[0] = 8'h0D; prog[1] = 8'h35; prog[2] = 8'h9C;
    prog[3] = 8'hE0; prog[4] = 8'hF0; prog[13] = 8'h5A;
    loadProg();
    runMode = 1'b1;
    edges(21);
    chk("R9 leds before instr 3 T4", leds, 8'd0);
    edges(1);
    chk("R3 R8 loaded value through no-ops", leds, 8'h5A);
    edges(5);
    chk("R9 halted before instr 4 T4", {7'd0, halted}, 8'd0);
    edges(1);
    chk("R9 halted at instr 4 T4", {7'd0, halted}, 8'd1);

    // R6 repeated output, R7 hold after halt
    doReset();
    clearProg();
    prog[0] = 8'h0E; prog[1] = 8'hE0; prog[2] = 8'h2F;
    prog[3] = 8'hE0; prog[4] = 8'hF0; prog[14] = 8'h10; prog[15] = 8'h01;
    loadProg();
    runMode = 1'b1;
    edges(10);
    chk("R6 first OUT", leds, 8'h10);
    edges(11);
    chk("R6 leds held between OUTs", leds, 8'h10);
    edges(1);
    chk("R6 second OUT", leds, 8'h0F);
    edges(16);
    chk("R7 leds held after halt", leds, 8'h0F);
    chk("R7 halted stays high", {7'd0, halted}, 8'd1);

    // R2 strobe ignored while running (also R11 on every run)
    doReset();
    clearProg();
    prog[0] = 8'h0E; prog[1] = 8'h1F; prog[2] = 8'hE0; prog[3] = 8'hF0;
    prog[14] = 8'd3; prog[15] = 8'd4;
    loadProg();
    runMode = 1'b1;
    addrSw = 4'd15; dataSw = 8'd100; writeStrobe = 1'b1;
    edges(1);
    writeStrobe = 1'b0;
    edges(15);
    chk("R2 run-mode write ignored", leds, 8'd7);

    // R10 wrap from 15 to 0
    doReset();
    clearProg();
    prog[0] = 8'h1E; prog[1] = 8'hE0;
    for (int i = 2; i < 14; i++) prog[i] = 8'h30;
    prog[14] = 8'h31; prog[15] = 8'h30;
    loadProg();
    runMode = 1'b1;
    edges(10);
    chk("R10 first pass output", leds, 8'h31);
    edges(95);
    chk("R10 before wrapped OUT", leds, 8'h31);
    edges(1);
    chk("R10 wrapped ADD and OUT", leds, 8'h62);

    // R1 reset mid-run
    rstN = 1'b0;
    #1;
    chk("R1 leds cleared by mid-run reset", leds, 8'd0);
    chk("R1 halted cleared by mid-run reset", {7'd0, halted}, 8'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule